// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block watches an incoming Ethernet frame as a byte stream and decides whether the frame is kept or dropped. A start strobe marks the first byte and a separate end strobe closes the frame. The first six bytes are the destination address. The block compares that address, one byte at a time as it arrives, against a configured 48-bit station address. It also compares it against the all-ones broadcast address and against a short list of extra addresses. It counts every byte of the frame, including the CRC, and applies a length gate.

When the end strobe arrives, the block raises exactly one of two single-cycle pulses: accept or discard. An option lets the individual-address compare ignore the universal/local bit. A second option keeps frames longer than the size limit instead of dropping them. All configuration is captured on the first byte, so it holds steady for the whole frame.

Top module: `rx_accept_filter`

## Requirements
- R1: A frame opens on a cycle with `rx_sof` and `rx_vld` both high and with `rx_eof` low. Such a cycle carries destination byte 0. `rx_eof` on an open frame raises exactly one of `frm_accept` and `frm_discard`, combinationally and for that one cycle only. `rx_eof` with no open frame raises neither.
- R2: The frame gets an individual-address match when all six destination bytes equal `cfg_station`. Byte i is compared with `cfg_station[8i+7:8i]`, and byte 0 arrives first.
- R3: With `cfg_ul_ignore` set, the individual-address compare skips bit 1 of destination byte 0. All other 47 bits must still match.
- R4: `cfg_ul_ignore` does not affect the broadcast compare or the list compare, which always test every bit. A frame accepted only through the skipped bit gets the same plain `frm_accept` pulse as any other accepted frame.
- R5: A destination of all ones (48'hFFFF_FFFF_FFFF) matches when `cfg_bcast_en` is set. It does not match through the broadcast rule when `cfg_bcast_en` is clear.
- R6: List entry k (`cfg_list[48k+47:48k]`, with the same byte order as R2) matches on an exact 48-bit compare, but only while `cfg_list_en[k]` is set.
- R7: With `cfg_mcast_all` set, any frame whose destination byte 0 has bit 0 set is a multicast frame, and it matches.
- R8: The length is the number of valid bytes from the start byte to the end strobe, CRC included. A frame longer than MAX_LEN (1518 by default) is discarded unless `cfg_long_ok` is set. A frame of at most MAX_LEN bytes passes the length gate.
- R9: The byte counter saturates one above MAX_LEN, so a frame of any length beyond the limit is still seen as long.
- R10: A frame with fewer than six bytes has no complete address and is discarded.
- R11: All configuration inputs are captured on the start byte. Changes made while a frame is open have no effect on that frame.
- R12: After reset, no frame is open and both decision outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start of frame, qualified by rx_vld |
| rx_vld | input | 1 | Byte valid |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | End of frame strobe (no byte on this cycle) |
| cfg_station | input | 48 | Individual station address, byte 0 in bits 7:0 |
| cfg_list | input | LIST_N*48 | Extra address list, entry k in bits 48k+47:48k |
| cfg_list_en | input | LIST_N | Per-entry enable for the list |
| cfg_ul_ignore | input | 1 | Skip the universal/local bit in the individual compare |
| cfg_long_ok | input | 1 | Keep frames longer than MAX_LEN |
| cfg_bcast_en | input | 1 | Accept broadcast |
| cfg_mcast_all | input | 1 | Accept every multicast frame |
| frm_accept | output | 1 | Keep pulse, on the end strobe |
| frm_discard | output | 1 | Drop pulse, on the end strobe |

## Verification
The bench builds the filter with MAX_LEN at 64 and LIST_N at 2. With these values the counter is only seven bits wide. A 300-byte frame would therefore wrap an unsaturated count back below the limit, so the saturation case can be reached in a few hundred cycles. The 64/65-byte boundary sits close to the address checks. Two list entries are enough to show that the list compare is exact and that each entry has its own enable, while the small list keeps the vector table short.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned DA_BYTES = 6;
  localparam int unsigned ADDR_W   = 48;

  typedef struct packed {
    logic ul_ign;
    logic long_ok;
    logic bc_en;
    logic mc_all;
  } rxf_mode_t;

  // Pick byte idx out of a 48-bit address (byte 0 in the low bits).
  function automatic logic [7:0] addr_byte(input logic [ADDR_W-1:0] a,
                                           input logic [2:0] idx);
    return a[{idx, 3'b000} +: 8];
  endfunction

  // Individual-address byte compare; on byte 0 the U/L bit may be masked.
  function automatic logic ia_byte_eq(input logic [7:0] d,
                                      input logic [7:0] s,
                                      input logic       first,
                                      input logic       ul_ign);
    logic [7:0] m;
    m = (first && ul_ign) ? 8'hFD : 8'hFF;
    return ((d ^ s) & m) == 8'h00;
  endfunction

  // Final keep decision from the completed address flags and length.
  function automatic logic keep_frame(input logic      da_full,
                                      input logic      ia,
                                      input logic      bc,
                                      input logic      lst,
                                      input logic      mc,
                                      input rxf_mode_t m,
                                      input logic      too_long);
    logic hit;
    hit = da_full && (ia || (bc && m.bc_en) || lst || (mc && m.mc_all));
    return hit && (!too_long || m.long_ok);
  endfunction

endpackage

// File: rtl/rxf_len_gate.sv
module rxf_len_gate #(
  parameter  int unsigned MAX_LEN = 1518,
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  output logic [CNT_W-1:0] cnt_o,
  output logic             long_o,
  output logic             da_full_o
);

  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] DA_V  = CNT_W'(rxf_pkg::DA_BYTES);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_sat;

  assign at_sat = (cnt_q == SAT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start)            cnt_q <= ONE_V;
    else if (beat && !at_sat)  cnt_q <= cnt_q + ONE_V;
  end

  assign cnt_o     = cnt_q;
  assign long_o    = (cnt_q > LIM_V);
  assign da_full_o = (cnt_q >= DA_V);

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !start && at_sat |=> cnt_q == SAT_V);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !start && !at_sat |=> cnt_q == $past(cnt_q) + ONE_V);

  // R1
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == ONE_V);

endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
  import rxf_pkg::*;
#(
  parameter int unsigned LIST_N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat,
  input  logic                     idx_ok,
  input  logic [2:0]               idx,
  input  logic [7:0]               d,
  input  logic [ADDR_W-1:0]        station,
  input  logic [LIST_N*ADDR_W-1:0] list,
  input  logic [LIST_N-1:0]        list_en,
  input  logic                     ul_ign,
  output logic                     ia_o,
  output logic                     bc_o,
  output logic                     lst_o,
  output logic                     mc_o
);

  logic              first;
  logic              ia_b;
  logic              bc_b;
  logic [LIST_N-1:0] lst_b;
  logic              ia_q, bc_q, mc_q;
  logic [LIST_N-1:0] lst_q;
  logic              take;

  assign first = (idx == 3'd0);
  assign take  = beat && idx_ok;
  assign ia_b  = ia_byte_eq(d, addr_byte(station, idx), first, ul_ign);
  assign bc_b  = (d == 8'hFF);

  for (genvar k = 0; k < LIST_N; k++) begin : g_list
    assign lst_b[k] = list_en[k] &&
                      (d == addr_byte(list[k*ADDR_W +: ADDR_W], idx));

    // R6
    list_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && !list_en[k] |=> !lst_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ia_q  <= 1'b0;
      bc_q  <= 1'b0;
      mc_q  <= 1'b0;
      lst_q <= '0;
    end else if (take) begin
      if (first) begin
        ia_q  <= ia_b;
        bc_q  <= bc_b;
        mc_q  <= d[0];
        lst_q <= lst_b;
      end else begin
        ia_q  <= ia_q & ia_b;
        bc_q  <= bc_q & bc_b;
        lst_q <= lst_q & lst_b;
      end
    end
  end

  assign ia_o  = ia_q;
  assign bc_o  = bc_q;
  assign lst_o = |lst_q;
  assign mc_o  = mc_q;

  // R4
  bc_full_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && d != 8'hFF |=> !bc_q);

  // R2
  ia_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !first && d != addr_byte(station, idx) |=> !ia_q);

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
  import rxf_pkg::*;
#(
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned LIST_N  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_sof,
  input  logic                     rx_vld,
  input  logic [7:0]               rx_data,
  input  logic                     rx_eof,
  input  logic [ADDR_W-1:0]        cfg_station,
  input  logic [LIST_N*ADDR_W-1:0] cfg_list,
  input  logic [LIST_N-1:0]        cfg_list_en,
  input  logic                     cfg_ul_ignore,
  input  logic                     cfg_long_ok,
  input  logic                     cfg_bcast_en,
  input  logic                     cfg_mcast_all,
  output logic                     frm_accept,
  output logic                     frm_discard
);

  localparam int unsigned      CNT_W = $clog2(MAX_LEN + 2);
  localparam logic [CNT_W-1:0] DA_V  = CNT_W'(DA_BYTES);

  // Named internal events
  logic start_evt, beat_evt, end_evt;
  logic open_q;

  // Configuration snapshot
  rxf_mode_t                  live_mode, snap_mode, cur_mode;
  logic [ADDR_W-1:0]          snap_station, cur_station;
  logic [LIST_N*ADDR_W-1:0]   snap_list, cur_list;
  logic [LIST_N-1:0]          snap_list_en, cur_list_en;

  logic [CNT_W-1:0] cnt;
  logic             too_long, da_full;
  logic [2:0]       idx;
  logic             idx_ok;
  logic             ia_hit, bc_hit, lst_hit, mc_hit;
  logic             keep;

  assign start_evt = rx_sof && rx_vld && !rx_eof;
  assign beat_evt  = rx_vld && !rx_eof && (open_q || start_evt);
  assign end_evt   = rx_eof && open_q;

  assign live_mode = '{ul_ign:  cfg_ul_ignore,
                       long_ok: cfg_long_ok,
                       bc_en:   cfg_bcast_en,
                       mc_all:  cfg_mcast_all};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q       <= 1'b0;
      snap_mode    <= '0;
      snap_station <= '0;
      snap_list    <= '0;
      snap_list_en <= '0;
    end else begin
      if (start_evt)   open_q <= 1'b1;
      else if (rx_eof) open_q <= 1'b0;
      if (start_evt) begin
        snap_mode    <= live_mode;
        snap_station <= cfg_station;
        snap_list    <= cfg_list;
        snap_list_en <= cfg_list_en;
      end
    end
  end

  // On the start byte the live values are the ones being captured.
  assign cur_mode    = start_evt ? live_mode   : snap_mode;
  assign cur_station = start_evt ? cfg_station : snap_station;
  assign cur_list    = start_evt ? cfg_list    : snap_list;
  assign cur_list_en = start_evt ? cfg_list_en : snap_list_en;

  rxf_len_gate #(.MAX_LEN(MAX_LEN)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .beat      (beat_evt),
    .cnt_o     (cnt),
    .long_o    (too_long),
    .da_full_o (da_full)
  );

  assign idx    = start_evt ? 3'd0 : cnt[2:0];
  assign idx_ok = start_evt || (cnt < DA_V);

  rxf_addr_match #(.LIST_N(LIST_N)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat_evt),
    .idx_ok  (idx_ok),
    .idx     (idx),
    .d       (rx_data),
    .station (cur_station),
    .list    (cur_list),
    .list_en (cur_list_en),
    .ul_ign  (cur_mode.ul_ign),
    .ia_o    (ia_hit),
    .bc_o    (bc_hit),
    .lst_o   (lst_hit),
    .mc_o    (mc_hit)
  );

  assign keep        = keep_frame(da_full, ia_hit, bc_hit, lst_hit, mc_hit,
                                  snap_mode, too_long);
  assign frm_accept  = end_evt && keep;
  assign frm_discard = end_evt && !keep;

  // R1
  no_orphan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> !frm_accept && !frm_discard);

  // R1
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_accept || frm_discard |=> !frm_accept && !frm_discard);

  // R8
  long_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt && too_long && !snap_mode.long_ok |-> frm_discard);

  // R10
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt && !da_full |-> frm_discard);

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q && !start_evt |=> $stable(snap_mode) && $stable(snap_station)
                             && $stable(snap_list_en));

endmodule

// File: tb/rx_accept_filter_bench.sv
module rx_accept_filter_bench;

  localparam int unsigned MAX_LEN = 64;
  localparam int unsigned LIST_N  = 2;

  localparam logic [47:0] ST  = 48'h665544332210;
  localparam logic [47:0] ST2 = 48'h665544332212;
  localparam logic [47:0] L0  = 48'h22115E000001;
  localparam logic [47:0] L1  = 48'hCCBBAA998812;
  localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;

  // {da[68:21], len[20:5], ul[4], long_ok[3], bc_en[2], mc_all[1], exp[0]}
  localparam int NV = 21;
  localparam logic [68:0] VEC [NV] = '{
    {ST,                 16'd60,  5'b0000_1}, // R2
    {ST2,                16'd60,  5'b0000_0}, // R3 bit compared
    {ST2,                16'd60,  5'b1000_1}, // R3 bit skipped
    {48'h665544332010,   16'd60,  5'b1000_0}, // R3 other bits kept
    {BC,                 16'd60,  5'b0010_1}, // R5
    {BC,                 16'd60,  5'b0000_0}, // R5 disabled
    {48'hFFFFFFFFFFFD,   16'd60,  5'b1010_0}, // R4 bc full compare
    {L0,                 16'd60,  5'b0000_1}, // R6
    {48'h22115E000003,   16'd60,  5'b1000_0}, // R4 list full compare
    {48'h22115E000003,   16'd60,  5'b0001_1}, // R7
    {L1,                 16'd60,  5'b0000_1}, // R6
    {48'hCCBBAA998810,   16'd60,  5'b1000_0}, // R4
    {ST,                 16'd64,  5'b0000_1}, // R8 at limit
    {ST,                 16'd65,  5'b0000_0}, // R8 over limit
    {ST,                 16'd65,  5'b0100_1}, // R8 long ok
    {ST,                 16'd300, 5'b0000_0}, // R9
    {ST,                 16'd5,   5'b0000_0}, // R10
    {ST,                 16'd6,   5'b0000_1}, // R10 min
    {BC,                 16'd65,  5'b0010_0}, // R8 bc long
    {BC,                 16'd6,   5'b0001_1}, // R7 bc as multicast
    {ST,                 16'd300, 5'b0100_1}  // R9 long ok
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_sof = 1'b0, rx_vld = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [47:0] cfg_station = ST;
  logic [LIST_N*48-1:0] cfg_list = {L1, L0};
  logic [LIST_N-1:0] cfg_list_en = 2'b11;
  logic cfg_ul_ignore = 1'b0, cfg_long_ok = 1'b0;
  logic cfg_bcast_en = 1'b0, cfg_mcast_all = 1'b0;
  logic frm_accept, frm_discard;

  int errs = 0;
  int checks = 0;
  logic chg_ul = 1'b0, chg_lok = 1'b0;

  always #2 clk = ~clk;

  rx_accept_filter #(.MAX_LEN(MAX_LEN), .LIST_N(LIST_N)) u_rx_accept_filter (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_vld(rx_vld),
    .rx_data(rx_data), .rx_eof(rx_eof), .cfg_station(cfg_station),
    .cfg_list(cfg_list), .cfg_list_en(cfg_list_en),
    .cfg_ul_ignore(cfg_ul_ignore), .cfg_long_ok(cfg_long_ok),
    .cfg_bcast_en(cfg_bcast_en), .cfg_mcast_all(cfg_mcast_all),
    .frm_accept(frm_accept), .frm_discard(frm_discard));

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Sends a frame; at byte chg_at, applies chg_ul / chg_lok to the config.
  task automatic run_frame(input logic [47:0] da, input int len,
                           input int chg_at, input logic exp,
                           input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_vld  = 1'b1;
      rx_sof  = (i == 0);
      rx_data = (i < 6) ? da[8*i +: 8] : (8'h5A ^ 8'(i));
      if (i == chg_at) begin
        cfg_ul_ignore = chg_ul;
        cfg_long_ok   = chg_lok;
      end
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b1;
    #1;
    check(req, frm_accept, exp);
    check(req, frm_discard, !exp);
    @(negedge clk);
    rx_eof = 1'b0;
    #1;
    check("R1 pulse one cycle", frm_accept | frm_discard, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    #1;
    check("R12 accept in reset", frm_accept, 1'b0);
    check("R12 discard in reset", frm_discard, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 end strobe with no open frame
    rx_eof = 1'b1;
    #1;
    check("R1 orphan eof accept", frm_accept, 1'b0);
    check("R1 orphan eof discard", frm_discard, 1'b0);
    @(negedge clk);
    rx_eof = 1'b0;

    // Vector table
    for (int v = 0; v < NV; v++) begin
      cfg_ul_ignore = VEC[v][4];
      cfg_long_ok   = VEC[v][3];
      cfg_bcast_en  = VEC[v][2];
      cfg_mcast_all = VEC[v][1];
      run_frame(VEC[v][68:21], int'(VEC[v][20:5]), -1, VEC[v][0],
                $sformatf("R2-vector %0d", v));
    end

    // R11: ul ignore turned on mid-frame has no effect
    cfg_ul_ignore = 1'b0; cfg_long_ok = 1'b0;
    cfg_bcast_en = 1'b0; cfg_mcast_all = 1'b0;
    chg_ul = 1'b1; chg_lok = 1'b0;
    run_frame(ST2, 60, 2, 1'b0, "R11 ul change mid-frame");

    // R11: long ok cleared mid-frame has no effect
    cfg_ul_ignore = 1'b0; cfg_long_ok = 1'b1;
    chg_ul = 1'b0; chg_lok = 1'b0;
    run_frame(ST, 65, 10, 1'b1, "R11 long_ok change mid-frame");

    // R6: entry enable off
    cfg_long_ok = 1'b0;
    cfg_list_en = 2'b01;
    run_frame(L1, 60, -1, 1'b0, "R6 entry disabled");
    run_frame(L0, 60, -1, 1'b1, "R6 other entry enabled");
    cfg_list_en = 2'b11;

    // R4: frame accepted via skipped bit gives a plain accept pulse
    cfg_ul_ignore = 1'b1;
    run_frame(ST2, 60, -1, 1'b1, "R4 ul match plain accept");

    // R1: back-to-back frames
    cfg_ul_ignore = 1'b0;
    run_frame(ST, 8, -1, 1'b1, "R1 back-to-back a");
    run_frame(ST2, 8, -1, 1'b0, "R1 back-to-back b");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule